// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory up from power-on. After reset it holds the clock-enable pin low for a stable-clock interval. It then drives the full DDR2 mode-setting sequence onto a command bus, one command per strobe. The sequence covers a DLL-reset mode write, a second mode write without DLL reset, and the off-chip-driver calibration default and exit writes. Every wait is counted in clock cycles by one shared counter. The waits are derived from a clock-frequency parameter and rounded up.

The sequence runs once for chip select 0. When the rank-count input reads two, it runs again for chip select 1. A done flag then rises to tell the surrounding controller that periodic refresh may be switched on. The mode-register operating values are fixed parameters supplied by the integrator. The block only adds or clears the DLL-reset bit and the calibration field.

Top module: `ddr2_boot_seq`

## Requirements
- R1: After reset is released, `cke_o` is low and no command is strobed for exactly STABLE_CYC = STABLE_US*CLK_MHZ cycles. `cke_o` rises in the cycle of the first strobe and stays high until the next reset.
- R2: Each rank pass starts with a NOP (type 7). The next command follows max(ceil(NOP_WAIT_NS*CLK_MHZ/1000), CMD_GAP) cycles after the NOP.
- R3: The command order for each rank is fixed, with types PALL=1, REFA=5 and mode-register write=0:
  - NOP.
  - PALL with address bit 10 set.
  - Mode write to bank 2 with EMR2_OP.
  - Mode write to bank 3 with EMR3_OP.
  - Mode write to bank 1 with EMR1_OP.
  - Mode write to bank 0 with MR_OP plus bit 8 (DLL reset) set.
  - PALL with address bit 10 set.
  - REFA, then a second REFA.
  - Mode write to bank 0 with MR_OP and bit 8 cleared.
  - Mode write to bank 1 with EMR1_OP and bits 9:7 set to 111.
  - Mode write to bank 1 with EMR1_OP and bits 9:7 cleared.
  
  Non-mode commands other than PALL carry bank 0 and address 0.
- R4: The strobe-to-strobe spacing is CMD_GAP cycles in general, RFC_GAP after each REFA, and DLL_WAIT after the MRS without DLL reset.
- R5: `cmd_stb_o` is high for exactly one cycle per command.
- R6: `cmd_word_o` packs the command as follows, with every other bit zero and every field equal to its separate port during a strobe:
  - type in bits 27:24;
  - rank in bit 20;
  - bank in bits 17:16;
  - address in bits 15:0.
- R7: When `rank_cnt_i` is 2, a second pass of 12 commands follows with rank bit 1. For any other value, only the 12 rank-0 commands are issued.
- R8: `init_done_o` rises CMD_GAP cycles after the strobe of the final command. It then stays high with no further strobes until reset.
- R9: Asserting `rst_ni` at any point drops `cke_o`, `cmd_stb_o` and `init_done_o` at once. The next release restarts the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rank_cnt_i | input | 2 | Number of populated ranks (2 enables the second pass) |
| cke_o | output | 1 | DRAM clock enable |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| cmd_type_o | output | 4 | Command type code |
| cmd_bank_o | output | 2 | Bank / mode-register select |
| cmd_addr_o | output | ADDR_W | Row or mode-register value |
| cmd_rank_o | output | 1 | Chip-select index |
| cmd_word_o | output | 32 | Packed command word |
| init_done_o | output | 1 | Initialization finished, refresh may start |

## Verification
The bench measures the exact cycle of each strobe against the rounded-up waits. An off-by-one counter shows as a first command one cycle early or late. A shared wait applied to the wrong step moves the refresh or DLL spacing. It compares all 24 command words against values built from the mode parameters. A DLL-reset bit left set on the second MRS, or a calibration field left set on the exit write, therefore shows up directly. It runs with rank counts of 1, 2 and 3, where a misdecoded count adds or drops the second pass. It also resets mid-sequence to catch state that survives reset, and watches for strobes after done.

// File: rtl/ddr2_boot_pkg.sv
package ddr2_boot_pkg;

  typedef enum logic [3:0] {
    CMD_MRW  = 4'd0,
    CMD_PALL = 4'd1,
    CMD_REFA = 4'd5,
    CMD_NOP  = 4'd7
  } dram_cmd_e;

  typedef enum logic [1:0] {
    ST_PWRUP,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } seq_state_e;

  localparam int STEPS_PER_RANK = 12;
  localparam int STEP_W         = 4;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [31:0] pack_cmd(input logic [3:0] typ, input logic rank,
                                           input logic [1:0] bank, input logic [15:0] addr);
    return {4'b0, typ, 3'b0, rank, 2'b0, bank, addr};
  endfunction

endpackage

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
  parameter int CNT_W = 16,
  parameter int INIT  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CNT_W'(INIT);
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr2_step_rom.sv
module ddr2_step_rom
  import ddr2_boot_pkg::*;
#(
  parameter int                ADDR_W  = 14,
  parameter int                CNT_W   = 16,
  parameter logic [ADDR_W-1:0] MR_OP   = '0,
  parameter logic [ADDR_W-1:0] EMR1_OP = '0,
  parameter logic [ADDR_W-1:0] EMR2_OP = '0,
  parameter logic [ADDR_W-1:0] EMR3_OP = '0,
  parameter int                GAP_CMD = 2,
  parameter int                GAP_NOP = 2,
  parameter int                GAP_RFC = 2,
  parameter int                GAP_DLL = 2
) (
  input  logic [STEP_W-1:0] step_i,
  output dram_cmd_e         type_o,
  output logic [1:0]        bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  wait_o
);
  localparam logic [ADDR_W-1:0] DLL_RST  = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] OCD_MASK = ADDR_W'(7) << 7;
  localparam logic [ADDR_W-1:0] PALL_A10 = ADDR_W'(1) << 10;
  // load values: strobe-to-strobe spacing minus issue and terminal cycles
  localparam logic [CNT_W-1:0] W_CMD = CNT_W'(GAP_CMD - 2);
  localparam logic [CNT_W-1:0] W_NOP = CNT_W'(GAP_NOP - 2);
  localparam logic [CNT_W-1:0] W_RFC = CNT_W'(GAP_RFC - 2);
  localparam logic [CNT_W-1:0] W_DLL = CNT_W'(GAP_DLL - 2);

  always_comb begin
    type_o = CMD_MRW;
    bank_o = 2'd0;
    addr_o = '0;
    wait_o = W_CMD;
    case (step_i)
      4'd0:  begin type_o = CMD_NOP;  wait_o = W_NOP; end
      4'd1:  begin type_o = CMD_PALL; addr_o = PALL_A10; end
      4'd2:  begin bank_o = 2'd2; addr_o = EMR2_OP; end
      4'd3:  begin bank_o = 2'd3; addr_o = EMR3_OP; end
      4'd4:  begin bank_o = 2'd1; addr_o = EMR1_OP; end
      4'd5:  begin bank_o = 2'd0; addr_o = MR_OP | DLL_RST; end
      4'd6:  begin type_o = CMD_PALL; addr_o = PALL_A10; end
      4'd7,
      4'd8:  begin type_o = CMD_REFA; wait_o = W_RFC; end
      4'd9:  begin bank_o = 2'd0; addr_o = MR_OP & ~DLL_RST; wait_o = W_DLL; end
      4'd10: begin bank_o = 2'd1; addr_o = EMR1_OP | OCD_MASK; end
      4'd11: begin bank_o = 2'd1; addr_o = EMR1_OP & ~OCD_MASK; end
      default: begin type_o = CMD_NOP; end
    endcase
  end
endmodule

// File: rtl/ddr2_boot_fsm.sv
module ddr2_boot_fsm
  import ddr2_boot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zero_i,
  input  logic              two_rank_i,
  output logic              issue_o,
  output logic              cke_o,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o,
  output logic              rank_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS_PER_RANK - 1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic              rank_q, cke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWRUP;
      step_q  <= '0;
      rank_q  <= 1'b0;
      cke_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_PWRUP: if (zero_i) begin
          state_q <= ST_ISSUE;
          cke_q   <= 1'b1;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (zero_i) begin
          if (step_q != LAST_STEP) begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_ISSUE;
          end else if (!rank_q && two_rank_i) begin
            step_q  <= '0;
            rank_q  <= 1'b1;
            state_q <= ST_ISSUE;
          end else begin
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign issue_o = (state_q == ST_ISSUE);
  assign done_o  = (state_q == ST_DONE);
  assign cke_o   = cke_q;
  assign step_o  = step_q;
  assign rank_o  = rank_q;
endmodule

// File: rtl/ddr2_boot_seq.sv
module ddr2_boot_seq
  import ddr2_boot_pkg::*;
#(
  parameter int                CLK_MHZ     = 200,
  parameter int                STABLE_US   = 200,
  parameter int                NOP_WAIT_NS = 400,
  parameter int                CMD_GAP     = 4,
  parameter int                RFC_GAP     = 26,
  parameter int                DLL_WAIT    = 200,
  parameter int                ADDR_W      = 14,
  parameter logic [ADDR_W-1:0] MR_OP       = ADDR_W'('h0442),
  parameter logic [ADDR_W-1:0] EMR1_OP     = ADDR_W'('h0400),
  parameter logic [ADDR_W-1:0] EMR2_OP     = '0,
  parameter logic [ADDR_W-1:0] EMR3_OP     = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        rank_cnt_i,
  output logic              cke_o,
  output logic              cmd_stb_o,
  output logic [3:0]        cmd_type_o,
  output logic [1:0]        cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              cmd_rank_o,
  output logic [31:0]       cmd_word_o,
  output logic              init_done_o
);
  localparam int STABLE_CYC = STABLE_US * CLK_MHZ;
  localparam int NOP_CYC    = (NOP_WAIT_NS * CLK_MHZ + 999) / 1000;
  localparam int GAP_CMD    = max_i(CMD_GAP, 2);
  localparam int GAP_NOP    = max_i(NOP_CYC, GAP_CMD);
  localparam int GAP_RFC    = max_i(RFC_GAP, GAP_CMD);
  localparam int GAP_DLL    = max_i(DLL_WAIT, GAP_CMD);
  localparam int MAX_WAIT   = max_i(max_i(STABLE_CYC, GAP_NOP), max_i(GAP_RFC, GAP_DLL));
  localparam int CNT_W      = $clog2(MAX_WAIT + 1);
  localparam int MIN_GAP    = GAP_CMD;

  logic              zero, issue, cke, done, rank;
  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  wait_val;
  dram_cmd_e         typ;
  logic [1:0]        bank;
  logic [ADDR_W-1:0] addr;

  ddr2_wait_timer #(.CNT_W(CNT_W), .INIT(STABLE_CYC - 1)) u_timer (
    .clk_i, .rst_ni, .load_i(issue), .val_i(wait_val), .zero_o(zero)
  );

  ddr2_boot_fsm u_fsm (
    .clk_i, .rst_ni, .zero_i(zero), .two_rank_i(rank_cnt_i == 2'd2),
    .issue_o(issue), .cke_o(cke), .done_o(done), .step_o(step), .rank_o(rank)
  );

  ddr2_step_rom #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MR_OP(MR_OP), .EMR1_OP(EMR1_OP),
    .EMR2_OP(EMR2_OP), .EMR3_OP(EMR3_OP), .GAP_CMD(GAP_CMD), .GAP_NOP(GAP_NOP),
    .GAP_RFC(GAP_RFC), .GAP_DLL(GAP_DLL)
  ) u_rom (
    .step_i(step), .type_o(typ), .bank_o(bank), .addr_o(addr), .wait_o(wait_val)
  );

  assign cke_o       = cke;
  assign cmd_stb_o   = issue;
  assign cmd_type_o  = issue ? typ  : 4'd0;
  assign cmd_bank_o  = issue ? bank : 2'd0;
  assign cmd_addr_o  = issue ? addr : '0;
  assign cmd_rank_o  = issue & rank;
  assign cmd_word_o  = issue ? pack_cmd(typ, rank, bank, 16'(addr)) : 32'd0;
  assign init_done_o = done;
endmodule

// File: rtl/ddr2_boot_seq_chk.sv
module ddr2_boot_seq_chk #(
  parameter int STABLE_CYC = 1,
  parameter int MIN_GAP    = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] rank_cnt_i,
  input logic       cke_o,
  input logic       cmd_stb_o,
  input logic       cmd_rank_o,
  input logic       init_done_o
);
  logic [31:0] low_cnt, since_stb;
  logic        seen_stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt   <= '0;
      since_stb <= '0;
      seen_stb  <= 1'b0;
    end else begin
      if (!cke_o && low_cnt != '1) low_cnt <= low_cnt + 1'b1;
      if (cmd_stb_o) begin
        since_stb <= 32'd1;
        seen_stb  <= 1'b1;
      end else if (since_stb != '1) begin
        since_stb <= since_stb + 1'b1;
      end
    end
  end

  a_r1_cke_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> low_cnt >= STABLE_CYC);
  a_r1_no_cmd_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> !cmd_stb_o);
  a_r1_cke_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);
  a_r4_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_o && seen_stb) |-> since_stb >= MIN_GAP);
  a_r5_stb_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |=> !cmd_stb_o);
  a_r7_single_rank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_o && rank_cnt_i != 2'd2) |-> !cmd_rank_o);
  a_r8_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> !cmd_stb_o);
endmodule

bind ddr2_boot_seq ddr2_boot_seq_chk #(.STABLE_CYC(STABLE_CYC), .MIN_GAP(MIN_GAP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rank_cnt_i(rank_cnt_i), .cke_o(cke_o),
  .cmd_stb_o(cmd_stb_o), .cmd_rank_o(cmd_rank_o), .init_done_o(init_done_o)
);

// File: tb/ddr2_boot_seq_test.sv
`timescale 1ns/1ps
module ddr2_boot_seq_test;
  localparam int STABLE = 200 * 50;  // 200 us at 50 MHz
  localparam int GNOP = 20;          // ceil(400 ns * 50 MHz)
  localparam int GCMD = 3;
  localparam int GRFC = 8;
  localparam int GDLL = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rank_cnt = 2'd1;
  logic cke_o, cmd_stb_o, cmd_rank_o, init_done_o;
  logic [3:0] cmd_type_o;
  logic [1:0] cmd_bank_o;
  logic [13:0] cmd_addr_o;
  logic [31:0] cmd_word_o;

  int total = 0, bad = 0;
  int cyc;
  int n_log, cke_rise, done_cyc, pulse_err, low_err, after_done, field_err;
  logic prev_stb;
  logic [31:0] log_word [32];
  int log_cyc [32];

  always #10 clk = ~clk;

  ddr2_boot_seq #(
    .CLK_MHZ(50), .CMD_GAP(GCMD), .RFC_GAP(GRFC), .DLL_WAIT(GDLL),
    .MR_OP(14'h0442), .EMR1_OP(14'h0444), .EMR2_OP(14'h0080), .EMR3_OP(14'h0003)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .rank_cnt_i(rank_cnt), .cke_o, .cmd_stb_o,
    .cmd_type_o, .cmd_bank_o, .cmd_addr_o, .cmd_rank_o, .cmd_word_o, .init_done_o
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic clear_log();
    n_log = 0; cke_rise = -1; done_cyc = -1; pulse_err = 0; low_err = 0;
    after_done = 0; field_err = 0; prev_stb = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_stb_o) begin
        if (n_log < 32) begin log_word[n_log] = cmd_word_o; log_cyc[n_log] = cyc; end
        n_log++;
        if (prev_stb) pulse_err++;
        if (!cke_o) low_err++;
        if (done_cyc >= 0) after_done++;
        if (cmd_word_o[27:24] != cmd_type_o || cmd_word_o[20] != cmd_rank_o ||
            cmd_word_o[17:16] != cmd_bank_o || cmd_word_o[15:0] != {2'b0, cmd_addr_o} ||
            cmd_word_o[31:28] != 0 || cmd_word_o[23:21] != 0 || cmd_word_o[19:18] != 0)
          field_err++;
      end
      prev_stb = cmd_stb_o;
      if (cke_o && cke_rise < 0) cke_rise = cyc;
      if (init_done_o && done_cyc < 0) done_cyc = cyc;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int s, input int r);
    logic [3:0] t = 4'd0; logic [1:0] b = 2'd0; logic [15:0] a = 16'h0;
    case (s)
      0: t = 4'd7;
      1, 6: begin t = 4'd1; a = 16'h0400; end
      2: begin b = 2'd2; a = 16'h0080; end
      3: begin b = 2'd3; a = 16'h0003; end
      4: begin b = 2'd1; a = 16'h0444; end
      5: a = 16'h0542;
      7, 8: t = 4'd5;
      9: a = 16'h0442;
      10: begin b = 2'd1; a = 16'h07C4; end
      default: begin b = 2'd1; a = 16'h0444; end
    endcase
    return {4'b0, t, 3'b0, r[0], 2'b0, b, a};
  endfunction

  function automatic int exp_gap(input int s);
    case (s)
      0: return GNOP;
      7, 8: return GRFC;
      9: return GDLL;
      default: return GCMD;
    endcase
  endfunction

  task automatic start_run(input logic [1:0] rc);
    rst_n = 1'b0; rank_cnt = rc;
    repeat (3) @(negedge clk);
    check("R9 reset cke", cke_o, 0);
    check("R9 reset stb", cmd_stb_o, 0);
    check("R9 reset done", init_done_o, 0);
    clear_log();
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!init_done_o && n < 20000) begin @(negedge clk); n++; end
    repeat (60) @(negedge clk);
  endtask

  task automatic run_pass(input logic [1:0] rc, input int nranks);
    int last;
    start_run(rc);
    wait_done();
    check("R1 cke rise cycle", cke_rise, STABLE);
    check("R1 first strobe cycle", log_cyc[0], STABLE);
    check("R1 strobe with cke low", low_err, 0);
    check("R7 command count", n_log, 12 * nranks);
    check("R5 strobe width", pulse_err, 0);
    check("R6 packed fields", field_err, 0);
    for (int i = 0; i < 12 * nranks && i < 32; i++) begin
      check((i % 12 == 0) ? "R2 nop first" : "R3 command", log_word[i], exp_word(i % 12, i / 12));
      if (i > 0)
        check(((i - 1) % 12 == 0) ? "R2 nop wait" : "R4 spacing",
              log_cyc[i] - log_cyc[i-1], exp_gap((i - 1) % 12));
    end
    last = (n_log > 0 && n_log <= 32) ? log_cyc[n_log-1] : 0;
    check("R8 done cycle", done_cyc, last + GCMD);
    check("R8 done sticky", init_done_o, 1);
    check("R8 quiet after done", after_done, 0);
    check("R1 cke held", cke_o, 1);
  endtask

  task automatic mid_reset();
    int n = 0;
    start_run(2'd2);
    while (n_log < 3 && n < 20000) begin @(negedge clk); n++; end
    rst_n = 1'b0;
    #1;
    check("R9 cke drops", cke_o, 0);
    check("R9 done low", init_done_o, 0);
    check("R9 strobe low", cmd_stb_o, 0);
    @(negedge clk);
    clear_log();
    rst_n = 1'b1;
    n = 0;
    while (n_log < 1 && n < 20000) begin @(negedge clk); n++; end
    check("R9 restart wait", log_cyc[0], STABLE);
    check("R9 restart nop", log_word[0], exp_word(0, 0));
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_log();
    run_pass(2'd1, 1);
    run_pass(2'd2, 2);
    run_pass(2'd3, 1);
    mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule